// File: doc/BRIEF.md
# Feed-Protected PLL Control Registers

This block is the register unit that sits between a simple register bus and a clock multiplier (PLL). Software writes the desired enable, connect, multiplier and divider settings into staging registers. These staged values have no effect on the PLL. They are copied into the live registers only when software writes two specific key bytes back to back into a dedicated key register. A stray write to the control or configuration register therefore cannot stop the clock or retune it by accident.

The live registers drive the PLL's enable, connect (clock select), multiplier and divider pins. The PLL lock flag comes back as an input. A status register reports the live settings and the lock flag, so software can confirm that a commit took effect.

Reset forces everything to zero: the PLL is off and bypassed. A power-down request forces it off and bypassed immediately, whatever the live settings hold. A connect request is accepted only once the PLL is already enabled by an earlier commit and reports lock. This enforces the order configure, then enable, then connect.

Top module: `clkctl_feed_regs`

## Requirements
- R1: After reset, pll_en, pll_conn, pll_mul and pll_div are 0, and reading any register returns 0 except the lock bit of status.
- R2: A write to the control register (address 0: bit 0 enable, bit 1 connect) or to the configuration register (address 1: multiplier in bits [MUL_W-1:0], divider in bits [16+DIV_W-1:16]) is visible on read-back from the same address in the next cycle. It leaves the PLL outputs unchanged.
- R3: A write of 0xAA (low byte) to the key register (address 2), followed by a write of 0x55 as the next bus access, copies both staging registers into the live registers at the clock edge of the 0x55 write.
- R4: A read or write to any address between the 0xAA and the 0x55 cancels the sequence, so the 0x55 commits nothing. Idle bus cycles between them do not cancel it.
- R5: Any key value other than the expected one returns the key checker to idle without touching the live registers. This includes a second 0xAA, or a 0x55 with no preceding 0xAA.
- R6: On a commit, live connect becomes 1 only if staged connect is 1, staged enable is 1, the live enable was already 1 before the commit, and pll_lock is high. Otherwise live connect becomes 0.
- R7: A commit with staged enable 0 clears both live enable and live connect.
- R8: While pwr_down is high, pll_en and pll_conn are 0 at once, and the live enable and connect are cleared at the next edge. This holds even when that edge also carries a commit. A commit on that edge still loads the multiplier and divider.
- R9: The status register (address 3) reads bit 0 live enable, bit 1 live connect, bit 2 pll_lock, bits [8+MUL_W-1:8] live multiplier, bits [16+DIV_W-1:16] live divider, and all other bits 0.
- R10: Reading the key register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 config, 2 key, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pll_lock | input | 1 | Lock flag from the PLL |
| pwr_down | input | 1 | Power-down request, level |
| pll_en | output | 1 | PLL enable |
| pll_conn | output | 1 | Select PLL output as the system clock |
| pll_mul | output | MUL_W | Live multiplier value |
| pll_div | output | DIV_W | Live divider value |

## Verification
A commit and a power-down can land on the same clock edge, and so can a commit and a connect request that the lock or enable rule refuses. The bench raises pwr_down in the very cycle of the 0x55 write, with an enabled setting staged. It then expects enable and connect to be 0 while the new multiplier and divider are live. All sixteen combinations of staged enable, staged connect, prior live enable and lock are committed and compared against the gating rule. Exhaustive sweeps of the multiplier and divider fields check the pins and the status packing together.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_CFG  = 2'd1,
    A_KEY  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CFG_DIV_LSB  = 16;
  localparam int STAT_MUL_LSB = 8;
  localparam int STAT_DIV_LSB = 16;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;

  // connect is granted only on top of an already running, locked PLL
  function automatic logic conn_grant(input logic req_conn, input logic req_en,
                                      input logic cur_en, input logic lock);
    return req_conn & req_en & cur_en & lock;
  endfunction

endpackage

// File: rtl/clkctl_key_chk.sv
module clkctl_key_chk
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       access,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       commit,
  output logic       armed
);

  key_state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    commit    = 1'b0;
    if (access) begin
      if (state == KS_ARMED && key_wr && key_val == KEY_SECOND) begin
        commit    = 1'b1;
        state_nxt = KS_IDLE;
      end else if (state == KS_IDLE && key_wr && key_val == KEY_FIRST) begin
        state_nxt = KS_ARMED;
      end else begin
        state_nxt = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KS_IDLE;
    else        state <= state_nxt;
  end

  assign armed = (state == KS_ARMED);

  AST_COMMIT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> armed); // R3

  AST_KEY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && access && !commit) |=> !armed); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !access) |=> armed); // R4

endmodule

// File: rtl/clkctl_active_regs.sv
module clkctl_active_regs
  import clkctl_pkg::*;
#(
  parameter int MUL_W = 8,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             pd,
  input  logic             lock,
  input  logic             stg_en,
  input  logic             stg_conn,
  input  logic [MUL_W-1:0] stg_mul,
  input  logic [DIV_W-1:0] stg_div,
  output logic             act_en,
  output logic             act_conn,
  output logic [MUL_W-1:0] act_mul,
  output logic [DIV_W-1:0] act_div
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_conn <= 1'b0;
      act_mul  <= '0;
      act_div  <= '0;
    end else begin
      if (commit) begin
        act_mul  <= stg_mul;
        act_div  <= stg_div;
        act_en   <= stg_en;
        act_conn <= conn_grant(stg_conn, stg_en, act_en, lock);
      end
      if (pd) begin
        act_en   <= 1'b0;
        act_conn <= 1'b0;
      end
    end
  end

  AST_LIVE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_en, act_conn, act_mul, act_div}) |-> ($past(commit) || $past(pd))); // R3

  AST_CONN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    act_conn |-> act_en); // R7

  AST_CONN_RISE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_conn) |-> ($past(lock) && $past(act_en))); // R6

  AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!act_en && !act_conn)); // R8

endmodule

// File: rtl/clkctl_feed_regs.sv
module clkctl_feed_regs
  import clkctl_pkg::*;
#(
  parameter int MUL_W = 8,   // 1..8
  parameter int DIV_W = 5    // 1..8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             pll_lock,
  input  logic             pwr_down,
  output logic             pll_en,
  output logic             pll_conn,
  output logic [MUL_W-1:0] pll_mul,
  output logic [DIV_W-1:0] pll_div
);

  localparam int CFG_DIV_MSB = CFG_DIV_LSB + DIV_W - 1;

  logic             stg_en, stg_conn;
  logic [MUL_W-1:0] stg_mul;
  logic [DIV_W-1:0] stg_div;
  logic             act_en, act_conn;
  logic [MUL_W-1:0] act_mul;
  logic [DIV_W-1:0] act_div;
  logic             commit, armed;
  logic             wr_ctl, wr_cfg, wr_key;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctl = bus_sel & bus_wr & (bus_addr == A_CTL);
  assign wr_cfg = bus_sel & bus_wr & (bus_addr == A_CFG);
  assign wr_key = bus_wr & (bus_addr == A_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_en   <= 1'b0;
      stg_conn <= 1'b0;
      stg_mul  <= '0;
      stg_div  <= '0;
    end else begin
      if (wr_ctl) begin
        stg_en   <= bus_wdata[0];
        stg_conn <= bus_wdata[1];
      end
      if (wr_cfg) begin
        stg_mul <= bus_wdata[MUL_W-1:0];
        stg_div <= bus_wdata[CFG_DIV_MSB:CFG_DIV_LSB];
      end
    end
  end

  clkctl_key_chk u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .access  (bus_sel),
    .key_wr  (wr_key),
    .key_val (bus_wdata[7:0]),
    .commit  (commit),
    .armed   (armed)
  );

  clkctl_active_regs #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .pd       (pwr_down),
    .lock     (pll_lock),
    .stg_en   (stg_en),
    .stg_conn (stg_conn),
    .stg_mul  (stg_mul),
    .stg_div  (stg_div),
    .act_en   (act_en),
    .act_conn (act_conn),
    .act_mul  (act_mul),
    .act_div  (act_div)
  );

  assign pll_en   = act_en   & ~pwr_down;
  assign pll_conn = act_conn & ~pwr_down;
  assign pll_mul  = act_mul;
  assign pll_div  = act_div;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTL: begin
        bus_rdata[0] = stg_en;
        bus_rdata[1] = stg_conn;
      end
      A_CFG: begin
        bus_rdata[MUL_W-1:0]               = stg_mul;
        bus_rdata[CFG_DIV_MSB:CFG_DIV_LSB] = stg_div;
      end
      A_KEY: bus_rdata = '0;
      A_STAT: begin
        bus_rdata[0]                    = act_en;
        bus_rdata[1]                    = act_conn;
        bus_rdata[2]                    = pll_lock;
        bus_rdata[STAT_MUL_LSB +: MUL_W] = act_mul;
        bus_rdata[STAT_DIV_LSB +: DIV_W] = act_div;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_STAGE_NOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ctl || wr_cfg) && !pwr_down) |=> $stable({pll_en, pll_conn, pll_mul, pll_div})); // R2

endmodule

// File: tb/sim_clkctl_feed_regs.sv
module sim_clkctl_feed_regs;

  localparam int MW = 8;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [31:0]   bus_wdata = 32'd0;
  logic [31:0]   bus_rdata;
  logic          pll_lock = 1'b0, pwr_down = 1'b0;
  logic          pll_en, pll_conn;
  logic [MW-1:0] pll_mul;
  logic [DW-1:0] pll_div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkctl_feed_regs #(.MUL_W(MW), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .pwr_down(pwr_down), .pll_en(pll_en),
    .pll_conn(pll_conn), .pll_mul(pll_mul), .pll_div(pll_div)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  function automatic logic [31:0] cfg_word(input int m, input int dv);
    return (32'(dv) * 65536) + 32'(m);
  endfunction

  function automatic logic [31:0] stat_word(input bit e, input bit c, input bit l,
                                            input int m, input int dv);
    return 32'(dv) * 65536 + 32'(m) * 256 + 32'(l) * 4 + 32'(c) * 2 + 32'(e);
  endfunction

  function automatic logic [31:0] pins();
    return {pll_div, pll_mul, pll_conn, pll_en} & 32'h7FFFF;
  endfunction

  function automatic logic [31:0] pin_word(input bit e, input bit c, input int m, input int dv);
    return (32'(dv) << (MW + 2)) | (32'(m) << 2) | (32'(c) << 1) | 32'(e);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", pins(), 32'd0);
    rd(2'd0, r); chk("R1 ctl", r, 32'd0);
    rd(2'd1, r); chk("R1 cfg", r, 32'd0);
    rd(2'd3, r); chk("R1 status", r, 32'd0);

    // R2 staging only
    wr(2'd0, 32'h1);
    wr(2'd1, cfg_word(5, 3));
    rd(2'd0, r); chk("R2 ctl readback", r, 32'h1);
    rd(2'd1, r); chk("R2 cfg readback", r, cfg_word(5, 3));
    chk("R2 pins unchanged", pins(), 32'd0);

    // R3 valid commit
    feed();
    chk("R3 commit", pins(), pin_word(1, 0, 5, 3));
    rd(2'd3, r); chk("R9 status", r, stat_word(1, 0, 0, 5, 3));
    rd(2'd2, r); chk("R10 key reads 0", r, 32'd0);

    // R4 intervening read aborts
    wr(2'd1, cfg_word(9, 7));
    wr(2'd2, 32'hAA);
    rd(2'd0, r);
    wr(2'd2, 32'h55);
    chk("R4 read aborts", pins(), pin_word(1, 0, 5, 3));
    // intervening write aborts
    wr(2'd2, 32'hAA);
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h55);
    chk("R4 write aborts", pins(), pin_word(1, 0, 5, 3));
    // idle cycles do not abort
    wr(2'd2, 32'hAA);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h55);
    chk("R4 idle gap commits", pins(), pin_word(1, 0, 9, 7));

    // R5 wrong values
    wr(2'd1, cfg_word(20, 2));
    wr(2'd2, 32'hAA); wr(2'd2, 32'h56);
    chk("R5 wrong second", pins(), pin_word(1, 0, 9, 7));
    wr(2'd2, 32'h55);
    chk("R5 lone second", pins(), pin_word(1, 0, 9, 7));
    wr(2'd2, 32'hAA); wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    chk("R5 double first", pins(), pin_word(1, 0, 9, 7));
    feed();
    chk("R5 recovers", pins(), pin_word(1, 0, 20, 2));

    // R6/R7 connect gating sweep
    for (int k = 0; k < 16; k++) begin
      bit pe, he, hc, lk, expc;
      pe = k[0]; he = k[1]; hc = k[2]; lk = k[3];
      pll_lock = 1'b0;
      wr(2'd0, {31'd0, pe});
      feed();
      pll_lock = lk;
      wr(2'd0, {30'd0, hc, he});
      feed();
      expc = hc && he && pe && lk;
      chk("R6 connect gate", {30'd0, pll_conn, pll_en}, {30'd0, expc, he});
    end
    // R7 clearing enable drops connect
    pll_lock = 1'b1;
    wr(2'd0, 32'h1); feed();
    wr(2'd0, 32'h3); feed();
    chk("R7 connected", {30'd0, pll_conn, pll_en}, 32'h3);
    wr(2'd0, 32'h2); feed();
    chk("R7 disable clears", {30'd0, pll_conn, pll_en}, 32'h0);

    // R8 power-down
    wr(2'd0, 32'h1); feed();
    wr(2'd0, 32'h3); feed();
    @(negedge clk); pwr_down = 1'b1; #1;
    chk("R8 immediate off", {30'd0, pll_conn, pll_en}, 32'h0);
    @(negedge clk); pwr_down = 1'b0; #1;
    chk("R8 stays off", {30'd0, pll_conn, pll_en}, 32'h0);
    // R8 same edge as commit
    wr(2'd0, 32'h1);
    wr(2'd1, cfg_word(77, 11));
    wr(2'd2, 32'hAA);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h55; pwr_down = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; pwr_down = 1'b0; #1;
    chk("R8 pd wins over commit", pins(), pin_word(0, 0, 77, 11));

    // R3/R9 exhaustive multiplier and divider sweeps
    pll_lock = 1'b0;
    wr(2'd0, 32'h0);
    for (int m = 0; m < 256; m++) begin
      int dv;
      dv = m % 32;
      wr(2'd1, cfg_word(m, dv));
      feed();
      chk("R3 mul sweep", pins(), pin_word(0, 0, m, dv));
    end
    pll_lock = 1'b1;
    for (int dv = 0; dv < 32; dv++) begin
      int m;
      m = (dv * 37 + 11) % 256;
      wr(2'd1, cfg_word(m, dv));
      feed();
      rd(2'd3, r);
      chk("R9 status sweep", r, stat_word(0, 0, 1, m, dv));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule